// File: doc/BRIEF.md
# Nested Interrupt Level Tracker

This block records which interrupt priority levels a processor core is servicing at any moment. The core has four levels: low, medium, high and non-maskable. When the core enters a handler it sends an acknowledge pulse with a two-bit level code. When a handler finishes it sends a return pulse. The block keeps one active flag per level.

A higher level can preempt a lower one. When that happens the flags of the preempted levels stay set, so the flag set always shows the full nesting stack. Each return unwinds only the innermost level. The flags are presented as a read-only 8-bit status word. The block also drives a "highest active level" output, which a request front-end can use to mask requests of equal or lower priority.

Acknowledges that break the nesting order are refused and reported on a one-cycle error pulse. When an acknowledge and a return arrive in the same cycle, the return is applied first and the acknowledge second.

Top module: `ilt_tracker`

## Requirements
- R1: After reset the status word is 0x00, `topValid` is 0 and `protoErr` is 0.
- R2: Level codes map to status bits: code 0 (low) to bit 0, code 1 (medium) to bit 1, code 2 (high) to bit 2, and code 3 (non-maskable) to bit 7. An accepted acknowledge shows in the status word on the cycle after the pulse.
- R3: Status bits 6 down to 3 always read as zero.
- R4: An accepted acknowledge at a higher level leaves every flag that was already set still set, so the nesting stack is preserved.
- R5: A return pulse clears only the flag of the highest level that is currently set. Flags of lower, preempted levels are unchanged.
- R6: A return pulse while no flag is set changes nothing and raises no error.
- R7: An acknowledge is refused when its level's flag is already set, or when its level is not above the highest active level. A refused acknowledge leaves the status word unchanged and raises `protoErr` for exactly the following cycle.
- R8: A non-maskable acknowledge (code 3) is accepted whenever the non-maskable flag is clear, whatever other flags are set.
- R9: `topValid` is 1 exactly when some flag is set. `topLevel` then gives the level code (0 to 3) of the highest set flag.
- R10: An acknowledge and a return in the same cycle are handled as the return first, then the acknowledge. The legality of the acknowledge is judged against the flags left after the return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ackValid | input | 1 | Handler-entry acknowledge pulse |
| ackLevel | input | 2 | Level code of the acknowledge (0 low .. 3 non-maskable) |
| retValid | input | 1 | Handler-return pulse |
| statusWord | output | 8 | Read-only active-level status word |
| topValid | output | 1 | Some level is active |
| topLevel | output | 2 | Code of the highest active level |
| protoErr | output | 1 | One-cycle pulse after a refused acknowledge |

## Verification
The first pattern enters and leaves each level on its own. This pins down the bit each level code drives and confirms that the reserved bits stay clear. A full ascending climb from low to non-maskable, followed by a full unwind, tells a stack-preserving tracker apart from one that keeps only the current level. It also shows whether each return strips the innermost level or some other level. Out-of-order acknowledges (repeats, lower levels, high under non-maskable) are sent next and must leave the word untouched while pulsing the error output. Finally, coincident return-and-acknowledge pairs show whether the return is really applied first: a same-level re-entry and a medium entry after a high exit are both legal only under that ordering.

// File: rtl/ilt_pkg.sv
package ilt_pkg;

  // Number of tracked levels; the topmost index is the non-maskable level.
  localparam int unsigned NUM_LEVELS = 4;
  localparam int unsigned LEVEL_W    = $clog2(NUM_LEVELS);
  localparam int unsigned STATUS_W   = 8;

  typedef logic [NUM_LEVELS-1:0] levelMask_t;

  typedef struct packed {
    logic              valid;
    logic [LEVEL_W-1:0] idx;
  } topInfo_t;

  // Strobes the control path hands to the datapath each cycle.
  typedef struct packed {
    levelMask_t setMask;
    levelMask_t clrMask;
    logic       errPulse;
  } ctrlStrobe_t;

  // Highest set bit of a level mask.
  function automatic topInfo_t findTop(input levelMask_t m);
    topInfo_t r;
    r.valid = 1'b0;
    r.idx   = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (m[i]) begin
        r.valid = 1'b1;
        r.idx   = LEVEL_W'(i);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/ilt_ctrl.sv
module ilt_ctrl
  import ilt_pkg::*;
(
  input  logic               ackValid,
  input  logic [LEVEL_W-1:0] ackLevel,
  input  logic               retValid,
  input  levelMask_t         curFlags,
  output ctrlStrobe_t        strobe
);

  localparam logic [LEVEL_W-1:0] TOP_CODE = LEVEL_W'(NUM_LEVELS - 1);

  topInfo_t   curTop;
  topInfo_t   postTop;
  levelMask_t retClr;
  levelMask_t postRet;
  logic       ackIsTop;
  logic       ackAbove;
  logic       ackLegal;

  // Return is resolved first: strip the innermost active level.
  always_comb begin
    curTop = findTop(curFlags);
    retClr = '0;
    if (retValid && curTop.valid) begin
      retClr = levelMask_t'(1) << curTop.idx;
    end
    postRet = curFlags & ~retClr;
    postTop = findTop(postRet);
  end

  // Acknowledge is then judged against the post-return flags.
  always_comb begin
    ackIsTop = (ackLevel == TOP_CODE);
    ackAbove = !postTop.valid || (ackLevel > postTop.idx);
    ackLegal = !postRet[ackLevel] && (ackIsTop || ackAbove);

    strobe.clrMask  = retClr;
    strobe.setMask  = '0;
    strobe.errPulse = 1'b0;
    if (ackValid) begin
      if (ackLegal) begin
        strobe.setMask = levelMask_t'(1) << ackLevel;
      end else begin
        strobe.errPulse = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ilt_datapath.sv
module ilt_datapath
  import ilt_pkg::*;
#(
  parameter int unsigned STATUS_BITS = STATUS_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  output levelMask_t             curFlags,
  output logic [STATUS_BITS-1:0] statusWord,
  output logic                   topValid,
  output logic [LEVEL_W-1:0]     topLevel,
  output logic                   protoErr
);

  levelMask_t flagsQ;
  logic       errQ;
  topInfo_t   topNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ <= '0;
      errQ   <= 1'b0;
    end else begin
      flagsQ <= (flagsQ & ~strobe.clrMask) | strobe.setMask;
      errQ   <= strobe.errPulse;
    end
  end

  // Maskable levels fill the low bits; the non-maskable level sits at the MSB.
  for (genvar b = 0; b < STATUS_BITS; b++) begin : gStatus
    if (b < NUM_LEVELS - 1) begin : gLow
      assign statusWord[b] = flagsQ[b];
    end else if (b == STATUS_BITS - 1) begin : gNmi
      assign statusWord[b] = flagsQ[NUM_LEVELS-1];
    end else begin : gRsvd
      assign statusWord[b] = 1'b0;
    end
  end

  always_comb topNow = findTop(flagsQ);

  assign curFlags = flagsQ;
  assign topValid = topNow.valid;
  assign topLevel = topNow.idx;
  assign protoErr = errQ;

endmodule

// File: rtl/ilt_tracker.sv
module ilt_tracker
  import ilt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                ackValid,
  input  logic [LEVEL_W-1:0]  ackLevel,
  input  logic                retValid,
  output logic [STATUS_W-1:0] statusWord,
  output logic                topValid,
  output logic [LEVEL_W-1:0]  topLevel,
  output logic                protoErr
);

  ctrlStrobe_t strobe;
  levelMask_t  curFlags;

  ilt_ctrl uCtrl (
    .ackValid (ackValid),
    .ackLevel (ackLevel),
    .retValid (retValid),
    .curFlags (curFlags),
    .strobe   (strobe)
  );

  ilt_datapath #(.STATUS_BITS(STATUS_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .curFlags   (curFlags),
    .statusWord (statusWord),
    .topValid   (topValid),
    .topLevel   (topLevel),
    .protoErr   (protoErr)
  );

endmodule

// File: rtl/ilt_tracker_chk.sv
module ilt_tracker_chk
  import ilt_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                ackValid,
  input logic [LEVEL_W-1:0]  ackLevel,
  input logic                retValid,
  input logic [STATUS_W-1:0] statusWord,
  input logic                topValid,
  input logic [LEVEL_W-1:0]  topLevel,
  input logic                protoErr
);

  // R4
  ack_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !retValid) |=> ((statusWord & $past(statusWord)) == $past(statusWord)));

  // R5
  ret_strips_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && !ackValid && topValid) |=>
      ($countones(statusWord) + 1 == $countones($past(statusWord))));

  // R6
  idle_ret_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && !ackValid && !topValid) |=> ($stable(statusWord) && !protoErr));

  // R7
  err_needs_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> $past(ackValid));

  // R8
  nmi_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !retValid && ackLevel == LEVEL_W'(NUM_LEVELS - 1) && !statusWord[STATUS_W-1])
      |=> (statusWord[STATUS_W-1] && !protoErr));

  // R9
  none_means_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !topValid |-> (statusWord == '0));

endmodule

bind ilt_tracker ilt_tracker_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .ackValid   (ackValid),
  .ackLevel   (ackLevel),
  .retValid   (retValid),
  .statusWord (statusWord),
  .topValid   (topValid),
  .topLevel   (topLevel),
  .protoErr   (protoErr)
);

// File: tb/tb_ilt_tracker.sv
`timescale 1ns/1ps
module tb_ilt_tracker;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ackValid = 1'b0;
  logic [1:0] ackLevel = 2'd0;
  logic       retValid = 1'b0;
  logic [7:0] statusWord;
  logic       topValid;
  logic [1:0] topLevel;
  logic       protoErr;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  always #2.5 clk = ~clk;

  ilt_tracker dut (
    .clk        (clk),
    .rstN       (rstN),
    .ackValid   (ackValid),
    .ackLevel   (ackLevel),
    .retValid   (retValid),
    .statusWord (statusWord),
    .topValid   (topValid),
    .topLevel   (topLevel),
    .protoErr   (protoErr)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=0x%02h expected=0x%02h", req, what, act, exp);
    end
  endtask

  // Check status, {topValid,topLevel} and error pulse together.
  task automatic checkAll(input string req, input logic [7:0] expStat, input logic [2:0] expTop, input logic expErr);
    check(req, "status", statusWord, expStat);
    check(req, "top", {5'd0, topValid, topLevel}, {5'd0, expTop});
    check(req, "err", {7'd0, protoErr}, {7'd0, expErr});
    check("R3", "reserved", {4'd0, statusWord[6:3]}, 8'h00);
  endtask

  // Drive one cycle of inputs at a falling edge; results are visible at the next falling edge.
  task automatic drive(input logic ack, input logic [1:0] lvl, input logic ret);
    @(negedge clk);
    ackValid = ack;
    ackLevel = lvl;
    retValid = ret;
    @(negedge clk);
    ackValid = 1'b0;
    retValid = 1'b0;
  endtask

  task automatic testReset();
    checkAll("R1", 8'h00, 3'b000, 1'b0);
  endtask

  task automatic testMapping();
    drive(1, 2'd0, 0); checkAll("R2", 8'h01, 3'b100, 1'b0);
    drive(0, 2'd0, 1); checkAll("R2", 8'h00, 3'b000, 1'b0);
    drive(1, 2'd1, 0); checkAll("R2", 8'h02, 3'b101, 1'b0);
    drive(0, 2'd0, 1);
    drive(1, 2'd2, 0); checkAll("R2", 8'h04, 3'b110, 1'b0);
    drive(0, 2'd0, 1);
    drive(1, 2'd3, 0); checkAll("R2", 8'h80, 3'b111, 1'b0);
    drive(0, 2'd0, 1); checkAll("R9", 8'h00, 3'b000, 1'b0);
  endtask

  task automatic testNesting();
    drive(1, 2'd0, 0); checkAll("R4", 8'h01, 3'b100, 1'b0);
    drive(1, 2'd1, 0); checkAll("R4", 8'h03, 3'b101, 1'b0);
    drive(1, 2'd2, 0); checkAll("R4", 8'h07, 3'b110, 1'b0);
    drive(1, 2'd3, 0); checkAll("R4", 8'h87, 3'b111, 1'b0);
    drive(0, 2'd0, 1); checkAll("R5", 8'h07, 3'b110, 1'b0);
    drive(0, 2'd0, 1); checkAll("R5", 8'h03, 3'b101, 1'b0);
    drive(0, 2'd0, 1); checkAll("R5", 8'h01, 3'b100, 1'b0);
    drive(0, 2'd0, 1); checkAll("R9", 8'h00, 3'b000, 1'b0);
  endtask

  task automatic testEmptyReturn();
    drive(0, 2'd0, 1); checkAll("R6", 8'h00, 3'b000, 1'b0);
    drive(0, 2'd0, 1); checkAll("R6", 8'h00, 3'b000, 1'b0);
  endtask

  task automatic testErrors();
    drive(1, 2'd1, 0); checkAll("R7", 8'h02, 3'b101, 1'b0);
    drive(1, 2'd0, 0); checkAll("R7", 8'h02, 3'b101, 1'b1);
    drive(0, 2'd0, 0); checkAll("R7", 8'h02, 3'b101, 1'b0);
    drive(1, 2'd1, 0); checkAll("R7", 8'h02, 3'b101, 1'b1);
    drive(1, 2'd3, 0); checkAll("R8", 8'h82, 3'b111, 1'b0);
    drive(1, 2'd3, 0); checkAll("R7", 8'h82, 3'b111, 1'b1);
    drive(1, 2'd2, 0); checkAll("R7", 8'h82, 3'b111, 1'b1);
    drive(0, 2'd0, 1); checkAll("R5", 8'h02, 3'b101, 1'b0);
    drive(0, 2'd0, 1); checkAll("R5", 8'h00, 3'b000, 1'b0);
  endtask

  task automatic testSameCycle();
    drive(1, 2'd0, 0); checkAll("R10", 8'h01, 3'b100, 1'b0);
    drive(1, 2'd0, 1); checkAll("R10", 8'h01, 3'b100, 1'b0);
    drive(1, 2'd2, 0); checkAll("R10", 8'h05, 3'b110, 1'b0);
    drive(1, 2'd1, 1); checkAll("R10", 8'h03, 3'b101, 1'b0);
    drive(1, 2'd0, 1); checkAll("R10", 8'h01, 3'b100, 1'b1);
    drive(1, 2'd3, 1); checkAll("R8", 8'h80, 3'b111, 1'b0);
    drive(0, 2'd0, 1); checkAll("R6", 8'h00, 3'b000, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMapping();
    testNesting();
    testEmptyReturn();
    testErrors();
    testSameCycle();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testCount++;
      failCount++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule